// File: doc/BRIEF.md
# Dual-Lane Accumulator Interpolator Unit

This unit holds two accumulators, three base values and two lane configuration words behind a small synchronous register port. Each lane picks an accumulator, which is its own or, if configured, the other lane's. The lane shifts the value right, keeps a window of bits and can sign-extend from the top of that window. The lane value, or the raw accumulator if configured, is added to a base value to form the lane result. A third result sums both lane values with the third base.

Software reads results in three ways. A peek read returns a result and has no side effects. A pop read returns the same value and also writes the lane results back into the accumulators, so a loop of pops steps through a sequence. A raw read returns a lane value with no base added. Each lane can route the other lane's result into its own accumulator on a pop. This allows two-step stepping, where one accumulator advances by the other.

Top module: `interp_unit`

## Requirements
- R1: After reset, every accumulator, base register and configuration word reads as zero, and every result read returns zero.
- R2: Each lane works in a fixed order. First it shifts right by cfg[4:0], then it ANDs with the window from cfg[9:5] (low index) to cfg[14:10] (high index), then it sign-extends when cfg[15] is set. Example: with accumulator 0xdeadbeef, shift 8, window 4..7 and signed mode, the lane value is 0xffffffb0. The same setup without signed mode gives 0x000000b0.
- R3: The window bounds are inclusive. A low index of 0 with a high index of 31 passes the whole shifted word.
- R4: When the low index is greater than the high index, the window is empty. The lane value is then zero, and sign extension is not applied.
- R5: In signed mode the bit at the high window index is copied into every more-significant bit of the lane value.
- R6: Peek results: address 7 returns BASE0 plus the lane 0 addend, address 8 returns BASE1 plus the lane 1 addend, and address 9 returns BASE2 plus lane value 0 plus lane value 1.
- R7: A peek read leaves both accumulators unchanged.
- R8: A pop read (addresses 10, 11, 12 return the same values as 7, 8, 9) writes the lane 0 result into accumulator 0 and the lane 1 result into accumulator 1. The read returns the results from before the update.
- R9: When cfg[16] (cross input) is set, the lane takes the other lane's accumulator as its source.
- R10: When cfg[17] (cross result) is set, a pop writes the other lane's result into this lane's accumulator.
- R11: When cfg[18] (raw add) is set, the lane's unshifted source value is added to its base in place of the lane value.
- R12: Raw reads (address 13 for lane 0, 14 for lane 1) return the lane value after shift, window and sign extension, with no base added.
- R13: If a register write to an accumulator and a pop fall in the same cycle, the written value is the one the accumulator keeps. The other accumulator still takes its pop update.
- R14: Register map: ACC0=0, ACC1=1, BASE0=2, BASE1=3, BASE2=4, CFG0=5, CFG1=6. A write takes effect at the clock edge where wr_en is sampled. Read data appears on rd_data one clock after rd_en is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read data |

## Verification
A pop read and a register write to an accumulator can fall in the same clock edge, and both then try to load that accumulator. The bench provokes this by raising rd_en on a pop address and wr_en on accumulator 0 in the same cycle. It then reads both accumulators back. The written accumulator must hold the write data, while the other one must hold its pop result, and the pop itself must return the results from before the update.

// File: rtl/interp_unit.sv
module interp_unit #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int SW = $clog2(DW);
  localparam int CW = 3*SW + 4;
  localparam int B_SGN = 3*SW;
  localparam int B_XIN = 3*SW + 1;
  localparam int B_XRS = 3*SW + 2;
  localparam int B_RAW = 3*SW + 3;

  localparam logic [AW-1:0] A_ACC0 = 0, A_ACC1 = 1, A_BASE0 = 2, A_BASE1 = 3,
    A_BASE2 = 4, A_CFG0 = 5, A_CFG1 = 6, A_PEEK0 = 7, A_PEEK1 = 8, A_PEEK2 = 9,
    A_POP0 = 10, A_POP1 = 11, A_POP2 = 12, A_RAW0 = 13, A_RAW1 = 14;

  logic [DW-1:0] acc [2];
  logic [DW-1:0] base [3];
  logic [CW-1:0] cfg [2];
  logic [DW-1:0] lane_v [2];
  logic [DW-1:0] addend [2];
  logic [DW-1:0] res [2];
  logic [SW-1:0] lsb_f [2];
  logic [SW-1:0] msb_f [2];
  logic [DW-1:0] res2, rd_nxt;
  logic is_pop, is_peek;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [DW-1:0] src, shf, win, masked;
    assign lsb_f[i] = cfg[i][SW +: SW];
    assign msb_f[i] = cfg[i][2*SW +: SW];
    assign src    = cfg[i][B_XIN] ? acc[1-i] : acc[i];
    assign shf    = src >> cfg[i][0 +: SW];
    assign win    = (lsb_f[i] <= msb_f[i])
                  ? (({DW{1'b1}} << lsb_f[i]) & ({DW{1'b1}} >> (SW'(DW-1) - msb_f[i])))
                  : '0;
    assign masked = shf & win;
    assign lane_v[i] = (cfg[i][B_SGN] && masked[msb_f[i]])
                     ? (masked | ({DW{1'b1}} << msb_f[i])) : masked;
    assign addend[i] = cfg[i][B_RAW] ? src : lane_v[i];
    assign res[i]    = base[i] + addend[i];
  end

  assign res2    = base[2] + lane_v[0] + lane_v[1];
  assign is_pop  = rd_en && (rd_addr >= A_POP0) && (rd_addr <= A_POP2);
  assign is_peek = rd_en && (rd_addr >= A_PEEK0) && (rd_addr <= A_PEEK2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        acc[i] <= '0;
        cfg[i] <= '0;
      end
      for (int i = 0; i < 3; i++) base[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (wr_en && wr_addr == AW'(i)) acc[i] <= wr_data;
        else if (is_pop) acc[i] <= cfg[i][B_XRS] ? res[1-i] : res[i];
        if (wr_en && wr_addr == A_CFG0 + AW'(i)) cfg[i] <= wr_data[CW-1:0];
      end
      for (int i = 0; i < 3; i++)
        if (wr_en && wr_addr == A_BASE0 + AW'(i)) base[i] <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      A_ACC0:           rd_nxt = acc[0];
      A_ACC1:           rd_nxt = acc[1];
      A_BASE0:          rd_nxt = base[0];
      A_BASE1:          rd_nxt = base[1];
      A_BASE2:          rd_nxt = base[2];
      A_CFG0:           rd_nxt = DW'(cfg[0]);
      A_CFG1:           rd_nxt = DW'(cfg[1]);
      A_PEEK0, A_POP0:  rd_nxt = res[0];
      A_PEEK1, A_POP1:  rd_nxt = res[1];
      A_PEEK2, A_POP2:  rd_nxt = res2;
      A_RAW0:           rd_nxt = lane_v[0];
      A_RAW1:           rd_nxt = lane_v[1];
      default:          rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  // R4
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_f[0] > msb_f[0]) |-> (lane_v[0] == '0));

  // R7
  peek_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_peek && !wr_en) |=> ($stable(acc[0]) && $stable(acc[1])));

  // R13
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ACC0) |=> (acc[0] == $past(wr_data)));

  // R12
  raw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_RAW0) |=> (rd_data == $past(lane_v[0])));

  // R8
  pop_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_POP0) |=> (rd_data == $past(res[0])));
endmodule

// File: tb/interp_unit_tb_top.sv
module interp_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  interp_unit dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  // {acc0, cfg0, base0, expected PEEK0}
  localparam logic [127:0] VEC [8] = '{
    {32'hdeadbeef, 32'h00009C88, 32'h0, 32'hffffffb0},        // R2 R5 worked example
    {32'h12345678, 32'h00007C00, 32'h10, 32'h12345688},       // R3 full window
    {32'hdeadbeef, 32'h00001C88, 32'h0, 32'h000000b0},        // R2 unsigned
    {32'hffffffff, 32'h00008D00, 32'h5, 32'h00000005},        // R4 empty window, signed
    {32'h1234abcd, 32'h00003D80, 32'h0, 32'h0000a000},        // R3 nibble window
    {32'h80000000, 32'h00007C1F, 32'h1, 32'h00000002},        // R2 shift 31
    {32'h00000100, 32'h00047C04, 32'h20, 32'h00000120},       // R11 raw add
    {32'h0000000f, 32'h00008C00, 32'h0, 32'hffffffff}         // R5 extend from bit 3
  };

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R14 read latency
    rd(4'd0, v);  chk("R1 acc0", v, 0);
    rd(4'd4, v);  chk("R1 base2", v, 0);
    rd(4'd6, v);  chk("R1 cfg1", v, 0);
    rd(4'd9, v);  chk("R1 peek2", v, 0);

    for (int i = 0; i < 8; i++) begin
      wr(4'd0, VEC[i][127:96]);
      wr(4'd5, VEC[i][95:64]);
      wr(4'd2, VEC[i][63:32]);
      rd(4'd7, v);
      chk($sformatf("R2/R3/R4/R5/R11 vec %0d", i), v, VEC[i][31:0]);
    end
    rd(4'd5, v); chk("R14 cfg0 readback", v, 32'h00008C00);

    // R6 third result and lane 1
    wr(4'd5, 32'h7C00); wr(4'd6, 32'h7C00);
    wr(4'd0, 32'h10); wr(4'd1, 32'h20);
    wr(4'd2, 32'h1); wr(4'd3, 32'h100); wr(4'd4, 32'h3);
    rd(4'd9, v); chk("R6 peek2", v, 32'h33);
    rd(4'd8, v); chk("R6 peek1", v, 32'h120);
    // R7 peek leaves accumulators
    rd(4'd7, v); rd(4'd7, v); chk("R7 peek0", v, 32'h11);
    rd(4'd0, v); chk("R7 acc0 held", v, 32'h10);
    rd(4'd1, v); chk("R7 acc1 held", v, 32'h20);
    // R8 pop writes back
    wr(4'd3, 32'h2);
    rd(4'd10, v); chk("R8 pop0 value", v, 32'h11);
    rd(4'd0, v); chk("R8 acc0 updated", v, 32'h11);
    rd(4'd1, v); chk("R8 acc1 updated", v, 32'h22);
    // R9 cross input, R12 raw read
    wr(4'd5, 32'h17C00);
    rd(4'd7, v); chk("R9 cross input", v, 32'h23);
    rd(4'd13, v); chk("R12 raw0", v, 32'h22);
    wr(4'd5, 32'h9C88); wr(4'd0, 32'hdeadbeef);
    rd(4'd13, v); chk("R12 raw0 signed", v, 32'hffffffb0);
    // R10 cross result
    wr(4'd5, 32'h27C00); wr(4'd6, 32'h7C00);
    wr(4'd0, 32'h5); wr(4'd1, 32'h7);
    wr(4'd2, 32'h0); wr(4'd3, 32'h0);
    rd(4'd10, v);
    rd(4'd0, v); chk("R10 acc0 from lane1", v, 32'h7);
    rd(4'd1, v); chk("R10 acc1", v, 32'h7);
    // R13 write beats pop on same edge
    wr(4'd5, 32'h7C00);
    wr(4'd0, 32'h1); wr(4'd1, 32'h2);
    wr(4'd2, 32'h10); wr(4'd3, 32'h10);
    @(negedge clk);
    rd_en = 1; rd_addr = 4'd11; wr_en = 1; wr_addr = 4'd0; wr_data = 32'hAAAA;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    chk("R13 pop1 value", rd_data, 32'h12);
    rd(4'd0, v); chk("R13 acc0 write wins", v, 32'hAAAA);
    rd(4'd1, v); chk("R13 acc1 popped", v, 32'h12);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule